// File: doc/BRIEF.md
# Multichannel Interrupt Event Queue

This block collects interrupt events from up to 64 logical channels and logs them into a circular table. The table lives in a small internal memory. Each channel raises a request with a few event bits. The block picks one requester per clock and writes one entry for it at the current write position. An entry carries a valid flag, the event bits and the channel number. Software reads and clears entries through a simple host port, so the table acts as a queue from hardware to software.

Writes never clear stored bits. A new entry is ORed into whatever word sits in the slot. Software must therefore clear a handled entry completely, apart from its wrap flag. If the slot at the write position still holds a valid entry, the new event is thrown away and the older entry stays as it was. A queue-overflow flag is then raised in the event register instead. A frame counter raises the global-interrupt flag after a programmable number of frame events. The interrupt output is the OR of the event flags that the mask register enables.

Top module: `irq_event_queue`

## Requirements
- R1: A granted event with the target slot not valid stores, by OR, the word {bit15 valid=1, bit14 unchanged, bits 9:4 channel number, bits 3:0 event bits} at the write position. The position then advances by one.
- R2: Bits already stored in a slot, including junk left by software, stay set after a hardware write. The hardware only ORs.
- R3: A granted event whose target slot has bit 15 set is dropped. The slot is left unchanged and the write position does not move. Event register bit 1 (overflow) is set.
- R4: After the hardware writes a slot whose bit 14 (wrap) is set, or the last slot, the write position returns to slot 0.
- R5: Host address DEPTH is the event register: bit 0 is the global interrupt, bit 1 is overflow. Writing a 1 clears only that bit. A set from hardware in the same cycle wins over the clear.
- R6: Event bit 0 of a written entry counts as a received frame. Bit 0 of the event register is set when the count reaches the threshold at host address DEPTH+2 (reset value 1), and the count then restarts. A threshold of 0 acts as 1. Dropped events are not counted.
- R7: The mask register at host address DEPTH+1 has the event register's layout. `irq` is high exactly when some event bit and its mask bit are both set.
- R8: Among simultaneous requests, only the lowest-numbered requesting channel gets `ev_ack` in that cycle. At most one ack is high per clock.
- R9: A host write to a table address (below DEPTH) stores the host word as given. No event is granted in that cycle.
- R10: Reset sets the write position to 0. It clears the event and mask registers and the table, except that bit 14 is set in the last slot. The threshold is set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_req | input | NUM_CH | Per-channel event request, held until acknowledged |
| ev_bits | input | NUM_CH*4 | Four event bits per channel, channel c at bits 4c+3:4c |
| ev_ack | output | NUM_CH | One-hot acknowledge of the event served this cycle |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | ADDR_W | Host address: table slots, then event, mask, threshold |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Combinational read data at hst_addr |
| irq | output | 1 | Interrupt, any unmasked event flag |

## Verification
The hardest case to reach is the full ring. The write position has to come back to a slot that software has not cleared, and a drop has to fall in the same cycle as a write-1-to-clear of the overflow flag. The stimulus fills all slots with requests from many channels at once, so the pointer wraps through the wrap bit. It then keeps requesting against the valid slot 0 and issues the clear in a drop cycle. After that it moves the wrap bit to an earlier slot and leaves junk in a cleared slot, which shows the OR behaviour and the early return.

// File: rtl/irq_event_queue_pkg.sv
// Package: entry layout and event register layout of the interrupt event queue.
package irq_event_queue_pkg;
    localparam int ENTRY_W   = 16;
    localparam int VALID_BIT = 15;
    localparam int WRAP_BIT  = 14;
    localparam int CH_LSB    = 4;
    localparam int CH_W      = 6;
    localparam int EV_W      = 4;
    localparam int FRAME_BIT = 0;
    localparam int EVT_W     = 2;
    localparam int EVT_GINT  = 0;
    localparam int EVT_OVF   = 1;
endpackage

// File: rtl/irq_event_queue_arb.sv
// Fixed-priority arbiter: grants the lowest-numbered request while enabled.
// Assumes N >= 2. The grant is one-hot and purely combinational.
module irq_event_queue_arb #(
    parameter int N     = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic             en,
    output logic [N-1:0]     gnt,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;
    // Ripple chain: a request blocks every higher-numbered one.
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign gnt[g]    = en & req[g] & ~seen[g];
        assign seen[g+1] = seen[g] | req[g];
    end

    assign any = |gnt;

    // Encode the one-hot grant into a channel index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_event_queue_ring.sv
// Table memory: DEPTH words. The host write stores a word as given, while the
// hardware write ORs into the stored word. Assumes the two never coincide
// (the top blocks grants while the host writes the table). Two combinational
// read ports.
module irq_event_queue_ring
    import irq_event_queue_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_we,
    input  logic [PTR_W-1:0]   hw_addr,
    input  logic [ENTRY_W-1:0] hw_word,
    input  logic               sw_we,
    input  logic [PTR_W-1:0]   sw_addr,
    input  logic [ENTRY_W-1:0] sw_word,
    input  logic [PTR_W-1:0]   rd_addr_a,
    output logic [ENTRY_W-1:0] rd_word_a,
    input  logic [PTR_W-1:0]   rd_addr_b,
    output logic [ENTRY_W-1:0] rd_word_b
);
    logic [ENTRY_W-1:0] mem [DEPTH];

    // Reset to a cleared table with the wrap flag in the last slot; otherwise store or OR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i == DEPTH - 1) ? ENTRY_W'(1 << WRAP_BIT) : '0;
            end
        end else if (sw_we) begin
            mem[sw_addr] <= sw_word;
        end else if (hw_we) begin
            mem[hw_addr] <= mem[hw_addr] | hw_word;
        end
    end

    assign rd_word_a = mem[rd_addr_a];
    assign rd_word_b = mem[rd_addr_b];
endmodule

// File: rtl/irq_event_queue_regs.sv
// Event, mask and threshold registers plus the frame counter.
// Event bits are write-1-to-clear, and a set in the same cycle wins over the clear.
module irq_event_queue_regs
    import irq_event_queue_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we,
    input  logic [EVT_W-1:0] clr_bits,
    input  logic             mask_we,
    input  logic [EVT_W-1:0] mask_wdata,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             frame_done,
    input  logic             drop,
    output logic [EVT_W-1:0] evt,
    output logic [EVT_W-1:0] mask,
    output logic [THR_W-1:0] thr,
    output logic             irq
);
    logic [THR_W-1:0] cnt;
    logic [THR_W:0]   cnt_inc;
    logic [THR_W:0]   thr_eff;
    logic             hit;
    logic [EVT_W-1:0] set_bits;

    // Threshold zero behaves like one; hit when this frame completes the count.
    always_comb begin
        thr_eff = (thr == '0) ? (THR_W+1)'(1) : {1'b0, thr};
        cnt_inc = {1'b0, cnt} + (THR_W+1)'(1);
        hit     = frame_done && (cnt_inc >= thr_eff);
        set_bits           = '0;
        set_bits[EVT_GINT] = hit;
        set_bits[EVT_OVF]  = drop;
    end

    // Frame counter: count frames, restart on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (frame_done) cnt <= hit ? '0 : cnt_inc[THR_W-1:0];
    end

    // Event register: write-1-to-clear first, hardware sets on top.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= '0;
        else        evt <= (clr_we ? (evt & ~clr_bits) : evt) | set_bits;
    end

    // Mask and threshold registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            thr  <= THR_W'(1);
        end else begin
            if (mask_we) mask <= mask_wdata;
            if (thr_we)  thr  <= thr_wdata;
        end
    end

    assign irq = |(evt & mask);
endmodule

// File: rtl/irq_event_queue.sv
// Top of the interrupt event queue. It grants one channel event per clock,
// logs it into the ring at the write pointer, or drops it when the slot is
// still valid. Assumes NUM_CH <= 64, DEPTH a power of two, THR_W <= 16.
module irq_event_queue
    import irq_event_queue_pkg::*;
#(
    parameter int NUM_CH  = 64,
    parameter int DEPTH   = 16,
    parameter int THR_W   = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int ADDR_W = $clog2(DEPTH + 3),
    localparam int IDX_W  = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      ev_req,
    input  logic [NUM_CH*EV_W-1:0] ev_bits,
    output logic [NUM_CH-1:0]      ev_ack,
    input  logic                   hst_wr,
    input  logic [ADDR_W-1:0]      hst_addr,
    input  logic [ENTRY_W-1:0]     hst_wdata,
    output logic [ENTRY_W-1:0]     hst_rdata,
    output logic                   irq
);
    localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(DEPTH);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(DEPTH + 1);
    localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(DEPTH + 2);

    logic               tab_wr;
    logic               any_gnt;
    logic [IDX_W-1:0]   gnt_idx;
    logic [PTR_W-1:0]   wptr;
    logic [ENTRY_W-1:0] slot_word;
    logic [ENTRY_W-1:0] host_word;
    logic [ENTRY_W-1:0] new_word;
    logic [EV_W-1:0]    sel_bits;
    logic               take;
    logic               drop;
    logic               frame_done;
    logic [EVT_W-1:0]   evt;
    logic [EVT_W-1:0]   mask;
    logic [THR_W-1:0]   thr;

    // A host write to the table takes the cycle from the event writer.
    assign tab_wr = hst_wr && (hst_addr < A_EVT);

    irq_event_queue_arb #(.N(NUM_CH)) i_arb (
        .req (ev_req),
        .en  (!tab_wr),
        .gnt (ev_ack),
        .any (any_gnt),
        .idx (gnt_idx)
    );

    // Build the entry for the granted channel; decide between write and drop.
    always_comb begin
        sel_bits   = ev_bits[gnt_idx*EV_W +: EV_W];
        new_word   = '0;
        new_word[VALID_BIT]              = 1'b1;
        new_word[CH_LSB +: CH_W]         = CH_W'(gnt_idx);
        new_word[EV_W-1:0]               = sel_bits;
        take       = any_gnt && !slot_word[VALID_BIT];
        drop       = any_gnt &&  slot_word[VALID_BIT];
        frame_done = take && sel_bits[FRAME_BIT];
    end

    irq_event_queue_ring #(.DEPTH(DEPTH)) i_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_we     (take),
        .hw_addr   (wptr),
        .hw_word   (new_word),
        .sw_we     (tab_wr),
        .sw_addr   (hst_addr[PTR_W-1:0]),
        .sw_word   (hst_wdata),
        .rd_addr_a (wptr),
        .rd_word_a (slot_word),
        .rd_addr_b (hst_addr[PTR_W-1:0]),
        .rd_word_b (host_word)
    );

    // Write pointer: advance after a write, back to base after a wrap-flagged or last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (take) begin
            if (slot_word[WRAP_BIT] || wptr == PTR_W'(DEPTH - 1)) wptr <= '0;
            else                                                 wptr <= wptr + PTR_W'(1);
        end
    end

    irq_event_queue_regs #(.THR_W(THR_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_we     (hst_wr && hst_addr == A_EVT),
        .clr_bits   (hst_wdata[EVT_W-1:0]),
        .mask_we    (hst_wr && hst_addr == A_MASK),
        .mask_wdata (hst_wdata[EVT_W-1:0]),
        .thr_we     (hst_wr && hst_addr == A_THR),
        .thr_wdata  (hst_wdata[THR_W-1:0]),
        .frame_done (frame_done),
        .drop       (drop),
        .evt        (evt),
        .mask       (mask),
        .thr        (thr),
        .irq        (irq)
    );

    // Host read multiplexer over table slots and registers.
    always_comb begin
        hst_rdata = '0;
        if (hst_addr < A_EVT)        hst_rdata = host_word;
        else if (hst_addr == A_EVT)  hst_rdata = ENTRY_W'(evt);
        else if (hst_addr == A_MASK) hst_rdata = ENTRY_W'(mask);
        else if (hst_addr == A_THR)  hst_rdata = ENTRY_W'(thr);
    end
endmodule

// File: rtl/irq_event_queue_chk.sv
// Checker for the interrupt event queue, attached to every instance by bind.
module irq_event_queue_chk
    import irq_event_queue_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 5,
    parameter int PTR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CH-1:0]  ev_req,
    input logic [NUM_CH-1:0]  ev_ack,
    input logic               hst_wr,
    input logic [ADDR_W-1:0]  hst_addr,
    input logic               irq,
    input logic [PTR_W-1:0]   wptr,
    input logic [ENTRY_W-1:0] slot_word,
    input logic [EVT_W-1:0]   evt,
    input logic [EVT_W-1:0]   mask
);
    logic granted;
    assign granted = |ev_ack;

    assert_ack_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_ack));

    assert_ack_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        granted |-> ((ev_ack & ev_req) == ev_ack) && ((((ev_ack - 1'b1) & ev_req)) == '0));

    assert_host_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && hst_addr < ADDR_W'(DEPTH)) |-> !granted);

    assert_drop_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && slot_word[VALID_BIT]) |=> evt[EVT_OVF]);

    assert_drop_keeps_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && slot_word[VALID_BIT]) |=> $stable(wptr));

    assert_wrap_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && !slot_word[VALID_BIT] && slot_word[WRAP_BIT]) |=> (wptr == '0));

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0 || evt == '0) |-> !irq);
endmodule

bind irq_event_queue irq_event_queue_chk #(
    .NUM_CH (NUM_CH),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .PTR_W  (PTR_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_req    (ev_req),
    .ev_ack    (ev_ack),
    .hst_wr    (hst_wr),
    .hst_addr  (hst_addr),
    .irq       (irq),
    .wptr      (wptr),
    .slot_word (slot_word),
    .evt       (evt),
    .mask      (mask)
);

// File: tb/test_irq_event_queue.sv
// Bench: behavioural reference model compared against the design every clock.
module test_irq_event_queue;
    localparam int NCH = 64;
    localparam int DEP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   ev_req = '0;
    logic [255:0]  ev_bits = '0;
    logic [63:0]   ev_ack;
    logic          hst_wr = 1'b0;
    logic [4:0]    hst_addr = '0;
    logic [15:0]   hst_wdata = '0;
    logic [15:0]   hst_rdata;
    logic          irq;

    int errors = 0;
    int checks = 0;

    // Reference model state
    logic [15:0] m_tab [DEP];
    int          m_wp;
    logic [1:0]  m_evt, m_mask;
    int          m_thr, m_cnt;

    always #10 clk = ~clk;

    irq_event_queue i_irq_event_queue (
        .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .ev_bits(ev_bits), .ev_ack(ev_ack),
        .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .irq(irq)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] m_read(input int a);
        if (a < DEP)      return m_tab[a];
        if (a == DEP)     return {14'b0, m_evt};
        if (a == DEP + 1) return {14'b0, m_mask};
        if (a == DEP + 2) return 16'(m_thr);
        return 16'h0;
    endfunction

    // One clock: drive, compare before the edge, then advance the model.
    task automatic step(input string tag, input logic [63:0] req, input logic [3:0] bits,
                        input logic wr, input int addr, input logic [15:0] wd);
        int g;
        logic [63:0] eack;
        logic [1:0] setb;
        @(negedge clk);
        ev_req = req; ev_bits = {NCH{bits}}; hst_wr = wr; hst_addr = 5'(addr); hst_wdata = wd;
        #1;
        g = -1;
        if (!(wr && addr < DEP)) begin
            for (int i = 0; i < NCH; i++) if (req[i] && g < 0) g = i;
        end
        eack = (g >= 0) ? (64'b1 << g) : 64'b0;
        check(tag, "ack", ev_ack, eack);
        check(tag, "rdata", 64'(hst_rdata), 64'(m_read(addr)));
        check(tag, "irq", 64'(irq), 64'(|(m_evt & m_mask)));
        setb = 2'b00;
        if (g >= 0) begin
            if (m_tab[m_wp][15]) begin
                setb[1] = 1'b1;
            end else begin
                m_tab[m_wp] = m_tab[m_wp] | 16'h8000 | 16'(g << 4) | 16'(bits);
                if (bits[0]) begin
                    m_cnt++;
                    if (m_cnt >= ((m_thr == 0) ? 1 : m_thr)) begin setb[0] = 1'b1; m_cnt = 0; end
                end
                if (m_tab[m_wp][14] || m_wp == DEP - 1) m_wp = 0; else m_wp++;
            end
        end
        if (wr) begin
            if (addr < DEP)      m_tab[addr] = wd;
            else if (addr == DEP) m_evt = m_evt & ~wd[1:0];
            else if (addr == DEP + 1) m_mask = wd[1:0];
            else if (addr == DEP + 2) m_thr = int'(wd[7:0]);
        end
        m_evt = m_evt | setb;
    endtask

    // Serve a set of simultaneous requests, dropping each as it is acknowledged.
    task automatic serve(input string tag, input logic [63:0] req, input logic [3:0] bits);
        logic [63:0] r = req;
        while (r != 0) begin
            step(tag, r, bits, 1'b0, DEP, 16'h0);
            r = r & (r - 64'd1);
        end
    endtask

    task automatic dump(input string tag);
        for (int i = 0; i < DEP; i++) step(tag, 64'h0, 4'h0, 1'b0, i, 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEP; i++) m_tab[i] = 16'h0;
        m_tab[DEP-1] = 16'h4000;
        m_wp = 0; m_evt = 0; m_mask = 0; m_thr = 1; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R10: reset state of table and registers
        dump("R10");
        step("R10", 64'h0, 4'h0, 1'b0, DEP, 16'h0);
        step("R10", 64'h0, 4'h0, 1'b0, DEP + 2, 16'h0);
        // R7: unmask both flags
        step("R7", 64'h0, 4'h0, 1'b1, DEP + 1, 16'h3);
        // R1 and R6: single frame event from channel 5
        step("R1", 64'h20, 4'h1, 1'b0, 0, 16'h0);
        step("R6", 64'h0, 4'h0, 1'b0, 0, 16'h0);
        // R8: simultaneous requests, lowest channel first
        serve("R8", 64'h0000_0100_0000_0208, 4'h2);
        // R5: clear only the global flag
        step("R5", 64'h0, 4'h0, 1'b1, DEP, 16'h1);
        step("R5", 64'h0, 4'h0, 1'b0, DEP, 16'h0);
        // R6: threshold 3, a non-frame event does not count
        step("R6", 64'h0, 4'h0, 1'b1, DEP + 2, 16'h3);
        serve("R6", 64'h0000_0000_0000_0007, 4'h9);
        serve("R6", 64'h0000_0000_0000_0010, 4'h4);
        step("R6", 64'h0, 4'h0, 1'b0, DEP, 16'h0);
        step("R5", 64'h0, 4'h0, 1'b1, DEP, 16'h1);
        // R4 and R3: fill the ring, wrap, then hit a valid slot
        serve("R4", 64'hF000_0000_0000_0F00, 4'h8);
        serve("R3", 64'h0000_0000_0000_0003, 4'h1);
        dump("R3");
        step("R3", 64'h0, 4'h0, 1'b0, DEP, 16'h0);
        // R5: a drop in the same cycle as the overflow clear keeps the flag
        step("R5", 64'h4, 4'h1, 1'b1, DEP, 16'h2);
        step("R5", 64'h0, 4'h0, 1'b0, DEP, 16'h0);
        // R9: host table write blocks the grant in that cycle
        step("R9", 64'h80, 4'h1, 1'b1, 0, 16'h0);
        for (int i = 1; i < DEP; i++) step("R9", 64'h0, 4'h0, 1'b1, i, (i == DEP - 1) ? 16'h4000 : 16'h0);
        step("R5", 64'h0, 4'h0, 1'b1, DEP, 16'h3);
        // R2: junk left in slot 1 survives the hardware write
        step("R2", 64'h0, 4'h0, 1'b1, 1, 16'h0022);
        serve("R2", 64'h0000_0000_0000_0C00, 4'h4);
        step("R2", 64'h0, 4'h0, 1'b0, 1, 16'h0);
        // R4: wrap flag moved to slot 2 returns the pointer early
        step("R4", 64'h0, 4'h0, 1'b1, 2, 16'h4000);
        step("R6", 64'h0, 4'h0, 1'b1, DEP + 2, 16'h0);
        serve("R4", 64'h0000_0000_0000_0003, 4'h1);
        dump("R4");
        // R7: masking hides the flags
        step("R7", 64'h0, 4'h0, 1'b1, DEP + 1, 16'h0);
        step("R7", 64'h0, 4'h0, 1'b0, DEP, 16'h0);
        step("R7", 64'h0, 4'h0, 1'b1, DEP + 1, 16'h2);
        step("R7", 64'h0, 4'h0, 1'b0, DEP + 1, 16'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule